// File: doc/BRIEF.md
# Buffered PWM timer with request-fed compare

This block is a single-channel, edge-aligned PWM timer whose duty compare value is refilled once per PWM period by an external data mover. A free-running up counter steps from zero to a programmable modulus and then wraps. The output is driven high at the start of each period and pulled low when the counter reaches the active compare value.

The compare value is double-buffered. Software, or the data mover, writes a new value into a shadow buffer and then sets a load-enable flag. At the next counter wrap, the buffered value moves into the active register, but only if the flag is already set. The flag then clears itself.

A request output is raised at the compare match of each period to ask for the next value, and it stays up until an acknowledge pulse is seen. The request comes from the match point while the update happens at the wrap. If the mover sets the flag too late, the update slips by exactly one whole period and the value is not lost. A status output shows when a value sits in the buffer still waiting for its load-enable.

Top module: `pwm_dmafeed`

## Requirements
- R1: After reset the counter, active compare, buffer and load flag are zero, the run bit is clear, and `pwm_out`, `req` and `pend` are low.
- R2: Writing data bit 0 = 1 to address 3 starts the counter. The counter counts 0, 1, … up to the modulus M (written at address 0) and then wraps to 0, so one period lasts M+1 clocks.
- R3: In each period the output is high from count 0 for C clocks and low afterwards, where C is the active compare value. If C = 0 the output stays low for the whole period. If C ≥ M it stays high for all M+1 clocks.
- R4: A write to address 1 fills only the buffer. The active compare changes only at a counter wrap, and only if the load flag (set by writing data bit 0 = 1 to address 2) was set before that wrap edge. The flag clears when the transfer happens.
- R5: If the load flag is written in the wrap cycle or later, the old compare value is used for one more full period. The buffered value then takes effect at the following wrap.
- R6: When 1 ≤ C < M, `req` rises in the clock after the count equals C. It stays high until `ack` is sampled high, and drops in the clock after that.
- R7: When C = 0 or C ≥ M, no request is raised during that period.
- R8: `pend` is high while a value written to the buffer since the last transfer is waiting and the load flag is not set.
- R9: A new request is raised in every period that has a valid match, including a period whose active value did not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 modulus, 1 buffer, 2 load flag, 3 control |
| wr_data | input | CNT_W | Write data |
| ack | input | 1 | Acknowledge from the data mover, one clock pulse |
| req | output | 1 | Request for the next compare value |
| pwm_out | output | 1 | PWM output |
| pend | output | 1 | Buffered value waiting for load-enable |

## Verification
The bench builds the block with a 6-bit counter, a matching reset modulus and the combinational output stage. It then programs a modulus of 9, which gives ten-clock periods. With periods this short, nine full periods fit in a short run. Each write can be placed on any phase of a period, including the wrap clock itself, so the one-period slip, the all-high case at C ≥ M, the C = M boundary and the zero compare can all be reached in order.

// File: rtl/pwm_dmafeed_pkg.sv
`timescale 1ns/1ps
package pwm_dmafeed_pkg;
   typedef enum logic [1:0] {
      RA_MODULUS = 2'd0,
      RA_SHADOW  = 2'd1,
      RA_ARM     = 2'd2,
      RA_CTRL    = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/pwm_dmafeed_regs.sv
`timescale 1ns/1ps
module pwm_dmafeed_regs
   import pwm_dmafeed_pkg::*;
#(
   parameter int W = 8,
   parameter logic [W-1:0] MOD_INIT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         wrap,
   output logic [W-1:0] mod_q,
   output logic [W-1:0] shadow_q,
   output logic         run_q,
   output logic         xfer,
   output logic         pend_o
);
   reg_addr_e sel;
   logic      arm_q, waiting_q;
   logic      wr_mod, wr_shadow, set_arm, wr_ctrl;

   assign sel       = reg_addr_e'(wr_addr);
   assign wr_mod    = wr_en && (sel == RA_MODULUS);
   assign wr_shadow = wr_en && (sel == RA_SHADOW);
   assign set_arm   = wr_en && (sel == RA_ARM) && wr_data[0];
   assign wr_ctrl   = wr_en && (sel == RA_CTRL);
   assign xfer      = wrap && arm_q;
   assign pend_o    = waiting_q && !arm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_q     <= MOD_INIT;
         shadow_q  <= '0;
         run_q     <= 1'b0;
         arm_q     <= 1'b0;
         waiting_q <= 1'b0;
      end else begin
         if (wr_mod)    mod_q    <= wr_data;
         if (wr_shadow) shadow_q <= wr_data;
         if (wr_ctrl)   run_q    <= wr_data[0];
         arm_q     <= set_arm || (arm_q && !wrap);
         waiting_q <= wr_shadow || (waiting_q && !xfer);
      end
   end

   p_arm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !set_arm) |=> !arm_q);
   p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_shadow && !set_arm && !arm_q) |=> pend_o);
endmodule

// File: rtl/pwm_dmafeed_counter.sv
`timescale 1ns/1ps
module pwm_dmafeed_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] mod_q,
   output logic [W-1:0] cnt_q,
   output logic         wrap
);
   assign wrap = run && (cnt_q >= mod_q);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else if (run)  cnt_q <= cnt_q + 1'b1;
   end

   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0));
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_dmafeed_compare.sv
`timescale 1ns/1ps
module pwm_dmafeed_compare #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] cnt_q,
   input  logic [W-1:0] mod_q,
   input  logic         xfer,
   input  logic [W-1:0] shadow_q,
   output logic [W-1:0] act_q,
   output logic         match,
   output logic         pwm_o
);
   logic nonzero, saturate, level;

   assign nonzero  = (act_q != '0);
   assign saturate = (act_q >= mod_q);
   assign match    = run && nonzero && !saturate && (cnt_q == act_q);
   assign level    = run && nonzero && (saturate || (cnt_q < act_q));

   always_ff @(posedge clk) begin
      if (!rst_n)    act_q <= '0;
      else if (xfer) act_q <= shadow_q;
   end

   generate
      if (OUT_REG) begin : g_out_flop
         logic pwm_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= level;
         end
         assign pwm_o = pwm_q;
      end else begin : g_out_comb
         assign pwm_o = level;
      end
   endgenerate

   p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(act_q));
   p_act_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (act_q == $past(shadow_q)));
endmodule

// File: rtl/pwm_dmafeed_request.sv
`timescale 1ns/1ps
module pwm_dmafeed_request (
   input  logic clk,
   input  logic rst_n,
   input  logic match,
   input  logic ack,
   output logic req_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     req_q <= 1'b0;
      else if (match) req_q <= 1'b1;
      else if (ack)   req_q <= 1'b0;
   end

   p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !ack) |=> req_q);
   p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !match) |=> !req_q);
   p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(match));
endmodule

// File: rtl/pwm_dmafeed.sv
`timescale 1ns/1ps
module pwm_dmafeed #(
   parameter int CNT_W   = 8,
   parameter int RST_MOD = (1 << CNT_W) - 1,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ack,
   output logic             req,
   output logic             pwm_out,
   output logic             pend
);
   localparam logic [CNT_W-1:0] MOD_INIT = CNT_W'(RST_MOD);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_dmafeed: CNT_W must lie in 2..32");
      end
      if (RST_MOD < 1 || RST_MOD >= (1 << CNT_W)) begin : g_bad_mod
         $error("pwm_dmafeed: RST_MOD must fit in CNT_W bits and be nonzero");
      end
   endgenerate

   logic [CNT_W-1:0] mod_q, shadow_q, cnt_q, act_q;
   logic             run_q, xfer, wrap, match;

   pwm_dmafeed_regs #(.W(CNT_W), .MOD_INIT(MOD_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wrap(wrap), .mod_q(mod_q), .shadow_q(shadow_q),
      .run_q(run_q), .xfer(xfer), .pend_o(pend));

   pwm_dmafeed_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q), .mod_q(mod_q),
      .cnt_q(cnt_q), .wrap(wrap));

   pwm_dmafeed_compare #(.W(CNT_W), .OUT_REG(OUT_REG)) u_cmp (
      .clk(clk), .rst_n(rst_n), .run(run_q), .cnt_q(cnt_q), .mod_q(mod_q),
      .xfer(xfer), .shadow_q(shadow_q), .act_q(act_q), .match(match),
      .pwm_o(pwm_out));

   pwm_dmafeed_request u_req (
      .clk(clk), .rst_n(rst_n), .match(match), .ack(ack), .req_q(req));

   p_one_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> !match);
   p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == '0) |-> !match);
endmodule

// File: tb/tb_pwm_dmafeed.sv
`timescale 1ns/1ps
module tb_pwm_dmafeed;
   localparam int W    = 6;
   localparam int MODV = 9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         ack = 1'b0;
   logic         req, pwm_out, pend;

   int checks = 0, errors = 0;
   int exp_q[$];
   bit mon_on = 1'b0, started = 1'b0, done = 1'b0;
   int per = 0, ph = 0, hi = 0;

   always #5 clk = ~clk;

   pwm_dmafeed #(.CNT_W(W), .RST_MOD(63), .OUT_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ack(ack), .req(req), .pwm_out(pwm_out),
      .pend(pend));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (period %0d phase %0d)",
                  tag, act, exp, per, ph);
      end
   endtask

   // monitor: phase tracking and per-period scoreboard of high cycles
   always @(negedge clk) begin
      if (mon_on) begin
         if (started) begin
            if (ph == MODV) begin ph = 0; per++; end
            else ph++;
         end else started = 1'b1;
         if (ph == 0) hi = 0;
         if (pwm_out) hi++;
         if (ph == MODV && exp_q.size() > 0) begin
            check("R3 high clocks per period", hi, exp_q.pop_front());
         end
      end
   end

   task automatic wait_at(input int p, input int q);
      while (!(per == p && ph == q)) begin @(negedge clk); #1; end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      @(negedge clk); #1;
      ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #200000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 pwm after reset", pwm_out, 0);
      check("R1 req after reset", req, 0);
      check("R1 pend after reset", pend, 0);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      // expected high clocks for periods 0..8 (R3/R4/R5)
      exp_q = '{0, 4, 7, 7, 2, MODV + 1, 0, MODV + 1, MODV + 1};
      wr(2'd0, MODV);
      wr(2'd1, 4);
      check("R8 pend after buffer write", pend, 1);
      wr(2'd2, 1);
      check("R8 pend cleared by load flag", pend, 0);
      check("R4 pwm still low before run", pwm_out, 0);
      // start counter (R2)
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = W'(1);
      @(posedge clk); #1;
      wr_en = 1'b0; mon_on = 1'b1;
      @(negedge clk); #1;
      // period 0: active compare zero, no request (R7)
      wait_at(0, MODV);
      check("R7 no request with zero compare", req, 0);
      // period 1: compare 4
      wait_at(1, 5);
      check("R6 request after match at 4", req, 1);
      wr(2'd1, 7);
      wr(2'd2, 1);
      pulse_ack();
      check("R6 request dropped after ack", req, 0);
      // period 2: compare 7, flag written in wrap clock -> slip (R5)
      wait_at(2, 8);
      check("R6 request after match at 7", req, 1);
      wr(2'd1, 2);
      check("R8 pend while value waits", pend, 1);
      wr(2'd2, 1);
      // period 3 keeps 7; request still held from period 2
      wait_at(3, 1);
      check("R6 request held without ack", req, 1);
      pulse_ack();
      check("R6 request low after ack", req, 0);
      wait_at(3, 8);
      check("R9 new request in repeated period", req, 1);
      pulse_ack();
      // period 4: compare 2
      wait_at(4, 3);
      check("R6 request after match at 2", req, 1);
      wr(2'd1, 12);
      wr(2'd2, 1);
      pulse_ack();
      check("R6 request cleared", req, 0);
      // period 5: compare 12 >= modulus
      wait_at(5, 2);
      wr(2'd1, 0);
      wr(2'd2, 1);
      wait_at(5, MODV);
      check("R7 no request when compare above modulus", req, 0);
      // period 6: compare 0
      wait_at(6, 1);
      wr(2'd1, MODV);
      wr(2'd2, 1);
      wait_at(6, MODV);
      check("R7 no request with zero compare again", req, 0);
      // period 7: compare equals modulus
      wait_at(7, 2);
      wr(2'd1, 3);
      wait_at(7, 4);
      check("R8 pend without load flag", pend, 1);
      wait_at(7, MODV);
      check("R7 no request when compare equals modulus", req, 0);
      // period 8: no load flag, value stays buffered (R4)
      wait_at(8, 5);
      check("R4 pend persists across wrap without flag", pend, 1);
      check("R4 output still high with old compare", pwm_out, 1);
      wait_at(9, 1);
      check("R3 all expected periods scored", exp_q.size(), 0);
      finish_run();
   end
endmodule